// File: doc/BRIEF.md
# Flash Page Hamming Syndrome Corrector

This block receives two 3-byte error-correcting codes that belong to one 256-byte flash data block: the code stored in the spare area when the block was written, and the code the read datapath has just recomputed over the bytes it fetched. On a start strobe it XORs the two codes into a syndrome, classifies the syndrome and returns the result one clock later. The four outcomes are: the codes agree, a single data bit is wrong, a single bit of the stored code is wrong, or the damage cannot be repaired.

For a single data bit error the block gives the byte address inside the 256-byte block and the bit index inside that byte. The surrounding datapath then flips that bit in its buffer. For an error in the stored code it gives the corrected 3-byte code, which is the recomputed one, so that the caller can write it back. The syndrome uses interleaved line-parity pairs: each pair of adjacent bits (odd, even) carries a parity and its complement. A single data error therefore makes every checked pair complementary, and the odd bit of each pair is one bit of the error location.

Top module: `ecc_syndrome_corrector`

## Requirements
- R1: The syndrome is the bitwise XOR of the stored and recomputed codes. Byte s0 is bits 7:0, s1 is bits 15:8 and s2 is bits 23:16. An all-zero syndrome gives result class 2'b00 (no error).
- R2: The class is 2'b01 (data bit corrected) when the syndrome is nonzero and each bit pair (2k+1, 2k) holds two different values. This is checked for k = 0..3 in s0 and s1 and for k = 1..3 in s2.
- R3: For class 2'b01 the byte address is {s0[7], s0[5], s0[3], s0[1], s1[7], s1[5], s1[3], s1[1]}, listed from the most significant bit down.
- R4: For class 2'b01 the bit index is {s2[7], s2[5], s2[3]}, listed from the most significant bit down.
- R5: When the pair test fails and the syndrome has exactly one bit set, the class is 2'b10 (stored code corrected). The corrected-code output then equals the recomputed code.
- R6: Every other nonzero syndrome gives class 2'b11 (uncorrectable).
- R7: The result valid strobe is high in exactly the cycle after each cycle in which start is high, and low otherwise. Class, address, index and corrected code change only with a valid strobe and hold their values between strobes.
- R8: After a synchronous active-high reset, valid, class, byte address, bit index and corrected code are all zero.
- R9: Syndrome bits s2[1:0] take no part in the pair test. They do count toward the zero test and the single-bit test.
- R10: When the class is not 2'b01, the byte address and bit index are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Evaluate the two codes presented in this cycle |
| code_stored | input | 24 | Code read back from the spare area |
| code_calc | input | 24 | Code recomputed over the data block |
| res_valid | output | 1 | One-cycle strobe: result fields are new |
| res_class | output | 2 | 00 none, 01 data bit, 10 stored code bit, 11 uncorrectable |
| fix_byte | output | 8 | Byte address of the bad data bit |
| fix_bit | output | 3 | Bit index of the bad data bit |
| code_fixed | output | 24 | Corrected code (the recomputed code) |

## Verification
Every result is registered once, so res_valid and all result fields are due on the first rising edge after the cycle in which start is high. The bench drives inputs on falling edges. It checks the result on the following falling edge, half a cycle after that rising edge. On the falling edge after that it checks that the strobe has dropped and that the fields have kept their values. A back-to-back pair of starts confirms that a second result follows the first one cycle later with no gap.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'b00,
    CLS_DATA = 2'b01,
    CLS_CODE = 2'b10,
    CLS_FAIL = 2'b11
  } ecc_class_e;
endpackage

// File: rtl/ecc_syndrome.sv
module ecc_syndrome #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 3,
  localparam int CODE_W = BYTE_W * NBYTES
) (
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  output logic [CODE_W-1:0] syn
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign syn[i*BYTE_W +: BYTE_W] = code_a[i*BYTE_W +: BYTE_W] ^ code_b[i*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/ecc_pair_check.sv
module ecc_pair_check #(
  parameter int BYTE_W = 8,
  parameter int SKIP   = 0,
  localparam int PAIRS = BYTE_W / 2,
  localparam int USED  = PAIRS - SKIP
) (
  input  logic [BYTE_W-1:0] syn_byte,
  output logic              pairs_ok,
  output logic [USED-1:0]   odd_bits
);
  logic [USED-1:0] cmp;
  for (genvar k = SKIP; k < PAIRS; k++) begin : g_pair
    assign cmp[k-SKIP]      = syn_byte[2*k+1] ^ syn_byte[2*k];
    assign odd_bits[k-SKIP] = syn_byte[2*k+1];
  end
  assign pairs_ok = &cmp;
endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
  import ecc_fix_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CODE_W = 3 * BYTE_W,
  localparam int PAIRS  = BYTE_W / 2,
  localparam int IDX_W  = PAIRS - 1
) (
  input  logic [CODE_W-1:0] syn,
  output ecc_class_e        cls,
  output logic [BYTE_W-1:0] loc_byte,
  output logic [IDX_W-1:0]  loc_bit
);
  logic [2:0]       ok;
  logic [PAIRS-1:0] odd0, odd1;
  logic [IDX_W-1:0] odd2;

  ecc_pair_check #(.BYTE_W(BYTE_W), .SKIP(0)) u_p0 (
    .syn_byte(syn[0 +: BYTE_W]), .pairs_ok(ok[0]), .odd_bits(odd0));
  ecc_pair_check #(.BYTE_W(BYTE_W), .SKIP(0)) u_p1 (
    .syn_byte(syn[BYTE_W +: BYTE_W]), .pairs_ok(ok[1]), .odd_bits(odd1));
  ecc_pair_check #(.BYTE_W(BYTE_W), .SKIP(1)) u_p2 (
    .syn_byte(syn[2*BYTE_W +: BYTE_W]), .pairs_ok(ok[2]), .odd_bits(odd2));

  always_comb begin
    loc_byte = '0;
    loc_bit  = '0;
    if (syn == '0) begin
      cls = CLS_NONE;
    end else if (&ok) begin
      cls      = CLS_DATA;
      loc_byte = {odd0, odd1};
      loc_bit  = odd2;
    end else if ($countones(syn) == 1) begin
      cls = CLS_CODE;
    end else begin
      cls = CLS_FAIL;
    end
  end
endmodule

// File: rtl/ecc_syndrome_corrector.sv
module ecc_syndrome_corrector
  import ecc_fix_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CODE_W = 3 * BYTE_W,
  localparam int IDX_W  = BYTE_W / 2 - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CODE_W-1:0] code_stored,
  input  logic [CODE_W-1:0] code_calc,
  output logic              res_valid,
  output logic [1:0]        res_class,
  output logic [BYTE_W-1:0] fix_byte,
  output logic [IDX_W-1:0]  fix_bit,
  output logic [CODE_W-1:0] code_fixed
);
  logic [CODE_W-1:0] syn;
  ecc_class_e        cls_c;
  logic [BYTE_W-1:0] byte_c;
  logic [IDX_W-1:0]  bit_c;

  ecc_syndrome #(.BYTE_W(BYTE_W), .NBYTES(3)) u_syn (
    .code_a(code_stored), .code_b(code_calc), .syn(syn));

  ecc_classify #(.BYTE_W(BYTE_W)) u_cls (
    .syn(syn), .cls(cls_c), .loc_byte(byte_c), .loc_bit(bit_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_class  <= 2'b00;
      fix_byte   <= '0;
      fix_bit    <= '0;
      code_fixed <= '0;
    end else begin
      res_valid <= start;
      if (start) begin
        res_class  <= cls_c;
        fix_byte   <= byte_c;
        fix_bit    <= bit_c;
        code_fixed <= code_calc;
      end
    end
  end

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    start |=> res_valid); // R7
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !start |=> !res_valid); // R7
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> ($stable(res_class) && $stable(fix_byte) && $stable(code_fixed))); // R7
  AST_NONE_MATCH: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_class == 2'b00) |-> (code_fixed == $past(code_stored))); // R1
  AST_CODE_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_class == 2'b10) |-> ($countones(code_fixed ^ $past(code_stored)) == 1)); // R5
  AST_LOC_ZERO: assert property (@(posedge clk) disable iff (rst)
    (res_class != 2'b01) |-> (fix_byte == '0 && fix_bit == '0)); // R10
endmodule

// File: tb/tb_ecc_syndrome_corrector.sv
module tb_ecc_syndrome_corrector;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [23:0] code_stored = '0;
  logic [23:0] code_calc = '0;
  logic        res_valid;
  logic [1:0]  res_class;
  logic [7:0]  fix_byte;
  logic [2:0]  fix_bit;
  logic [23:0] code_fixed;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ecc_syndrome_corrector dut (
    .clk(clk), .rst(rst), .start(start),
    .code_stored(code_stored), .code_calc(code_calc),
    .res_valid(res_valid), .res_class(res_class),
    .fix_byte(fix_byte), .fix_bit(fix_bit), .code_fixed(code_fixed));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Syndrome for one data bit at byte address a, bit b (R2/R3/R4 encoding)
  function automatic logic [23:0] data_syn(input logic [7:0] a, input logic [2:0] b);
    logic [7:0] s0, s1, s2;
    for (int k = 0; k < 4; k++) begin
      s0[2*k+1] = a[4+k]; s0[2*k] = ~a[4+k];
      s1[2*k+1] = a[k];   s1[2*k] = ~a[k];
    end
    s2[1:0] = 2'b00;
    for (int k = 1; k < 4; k++) begin
      s2[2*k+1] = b[k-1]; s2[2*k] = ~b[k-1];
    end
    return {s2, s1, s0};
  endfunction

  task automatic run_case(input string req, input logic [23:0] calc, input logic [23:0] syn,
                          input logic [1:0] exp_cls, input logic [7:0] exp_byte,
                          input logic [2:0] exp_bit);
    @(negedge clk);
    code_calc = calc; code_stored = calc ^ syn; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    code_calc = ~calc; code_stored = calc;
    check({req, " valid"}, res_valid, 1);
    check({req, " class"}, res_class, exp_cls);
    check({req, " byte"}, fix_byte, exp_byte);
    check({req, " bit"}, fix_bit, exp_bit);
    check({req, " fixed"}, code_fixed, calc);
    @(negedge clk);
    check("R7 strobe drops", res_valid, 0);
    check("R7 class held", res_class, exp_cls);
    check("R7 fixed held", code_fixed, calc);
  endtask

  task automatic test_reset();
    check("R8 valid", res_valid, 0);
    check("R8 class", res_class, 0);
    check("R8 byte", fix_byte, 0);
    check("R8 bit", fix_bit, 0);
    check("R8 fixed", code_fixed, 0);
  endtask

  task automatic test_none();
    run_case("R1 equal codes", 24'hA5C33C, 24'h0, 2'b00, 8'h00, 3'd0);
    run_case("R1 equal ones", 24'hFFFFFF, 24'h0, 2'b00, 8'h00, 3'd0);
  endtask

  task automatic test_data();
    run_case("R2 R3 R4 addr00 bit0", 24'h123456, data_syn(8'h00, 3'd0), 2'b01, 8'h00, 3'd0);
    run_case("R2 R3 R4 addrFF bit7", 24'h0F0F0F, data_syn(8'hFF, 3'd7), 2'b01, 8'hFF, 3'd7);
    run_case("R3 R4 addrA6 bit5", 24'hFFFFFF, data_syn(8'hA6, 3'd5), 2'b01, 8'hA6, 3'd5);
    run_case("R3 R4 addr19 bit2", 24'h3C3C3C, data_syn(8'h19, 3'd2), 2'b01, 8'h19, 3'd2);
  endtask

  task automatic test_low_bits_ignored();
    run_case("R9 s2 low bits set", 24'h55AA55, data_syn(8'h6C, 3'd3) | 24'h030000, 2'b01, 8'h6C, 3'd3);
    run_case("R9 R5 lone s2 bit0", 24'h00FF00, 24'h010000, 2'b10, 8'h00, 3'd0);
  endtask

  task automatic test_code_err();
    run_case("R5 bit23", 24'hCAFE01, 24'h800000, 2'b10, 8'h00, 3'd0);
    run_case("R5 bit0", 24'h000000, 24'h000001, 2'b10, 8'h00, 3'd0);
    run_case("R5 R10 bit9", 24'h7E7E7E, 24'h000200, 2'b10, 8'h00, 3'd0);
  endtask

  task automatic test_fail();
    run_case("R6 two bits", 24'h111111, 24'h000003, 2'b11, 8'h00, 3'd0);
    run_case("R6 one pair bad", 24'h222222, data_syn(8'h5A, 3'd1) ^ 24'h000040, 2'b11, 8'h00, 3'd0);
    run_case("R6 all ones", 24'h000000, 24'hFFFFFF, 2'b11, 8'h00, 3'd0);
  endtask

  task automatic test_back_to_back();
    @(negedge clk);
    code_calc = 24'h0; code_stored = data_syn(8'h33, 3'd6); start = 1'b1;
    @(negedge clk);
    check("R7 b2b first valid", res_valid, 1);
    check("R7 b2b first byte", fix_byte, 8'h33);
    code_calc = 24'h0; code_stored = 24'h000100;
    @(negedge clk);
    start = 1'b0;
    check("R7 b2b second valid", res_valid, 1);
    check("R7 b2b second class", res_class, 2'b10);
    check("R10 b2b byte cleared", fix_byte, 8'h00);
    @(negedge clk);
    check("R7 b2b drop", res_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_none();
    test_data();
    test_low_bits_ignored();
    test_code_err();
    test_fail();
    test_back_to_back();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule